// File: doc/BRIEF.md
# Burst Address Sequencer (Interleaved / Linear)

This block produces the address of each beat of a four-beat burst toward a synchronous pipelined memory or its controller. A start pulse captures a full external address; the low two bits become the burst's starting beat address and the upper bits are held for the whole burst. Each advance pulse moves to the next beat. A static order input picks one of two orderings: interleaved, where each beat is the start address XORed with the beat index, or linear, where each beat is the start address plus the beat index, modulo four. Either way the sequence stays inside the aligned group of four.

The block is control logic, so it has no valid/ready handshake. Its inputs are sampled pulses and it has no back-pressure. The clock-enable-bar input acts as a wait state: while it is high, no state changes. The address output is registered state seen through the ordering map. It shows the beat one clock after the start or advance that selects it. A flag marks the fourth beat, and the `burst_active` output says a burst has been loaded since reset.

Top module: `burst_addr_seq`

## Requirements
- R1: After reset, `addr_out` is 0 and both `last_beat` and `burst_active` are 0.
- R2: A start sampled with `cen_n` low loads `addr_in`. From the next cycle, `addr_out` equals `addr_in`, `burst_active` is 1, and the beat index is 0.
- R3: With `order_sel` = 1 (interleaved, the default sense), the low two bits of beat k equal the start low bits XOR k. From 01 this gives 01, 00, 11, 10.
- R4: With `order_sel` = 0 (linear), the low two bits of beat k equal the start low bits plus k, modulo 4. From 01 this gives 01, 10, 11, 00.
- R5: An advance sampled with `cen_n` low during an active burst moves one beat. An advance before any start leaves every output unchanged.
- R6: While `cen_n` is high, start and advance are ignored and all outputs hold.
- R7: A start in the middle of a burst restarts at beat 0 with the new address. A start takes priority over an advance in the same cycle.
- R8: `last_beat` is 1 exactly while an active burst is at beat 3. An advance from beat 3 wraps to beat 0, and the burst stays active.
- R9: The upper address bits (above bit 1) equal those captured at start for the whole burst, whatever `addr_in` does meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cen_n | input | 1 | Clock enable, active low; high inserts a wait state |
| order_sel | input | 1 | 1 = interleaved ordering, 0 = linear ordering |
| start | input | 1 | Load `addr_in` and begin a burst |
| advance | input | 1 | Step to the next beat |
| addr_in | input | ADDR_W | External starting address |
| addr_out | output | ADDR_W | Current beat address |
| last_beat | output | 1 | Current beat is the fourth |
| burst_active | output | 1 | A burst has been loaded |

## Verification
The bench walks every start offset in both orderings. A design that mixed up XOR and add would pass from 00 and 10 but fail from 01 and 11. It advances past the fourth beat, where a carry leaking into bit 2 would corrupt the upper address. It also checks a start arriving with an advance, and a start in mid-burst; a design that let the advance win would show beat 1 instead of the new start. Start and advance pulses given during a wait state, and an advance given before any burst, must leave the outputs frozen. A design that ignored the wait state or counted from idle would move the address.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORD_LINEAR      = 1'b0,
    ORD_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              start,
  input  logic              advance,
  output logic [BEAT_W-1:0] beat_idx,
  output logic              active,
  output logic              last
);
  localparam logic [BEAT_W-1:0] LAST_IDX = {BEAT_W{1'b1}};

  logic              take;
  logic              step;

  assign take = !cen_n && start;
  assign step = !cen_n && !start && advance && active;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beat_idx <= '0;
      active   <= 1'b0;
    end else if (take) begin
      beat_idx <= '0;
      active   <= 1'b1;
    end else if (step) begin
      beat_idx <= beat_idx + 1'b1;
    end
  end

  assign last = active && (beat_idx == LAST_IDX);

  // R6
  a_r6_wait_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(beat_idx) && $stable(active)));
  // R7
  a_r7_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && start) |=> (beat_idx == '0 && active));
  // R5
  a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !start && advance && active) |=>
      (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));
  // R8
  a_r8_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && !start && advance && last) |=> (beat_idx == '0 && active));
  // R5
  a_r5_idle_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !(!cen_n && start)) |=> (!active && beat_idx == '0));
endmodule

// File: rtl/burst_base_reg.sv
module burst_base_reg #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] base
);
  always_ff @(posedge clk) begin
    if (!rst_n)    base <= '0;
    else if (load) base <= addr_in;
  end

  // R9
  a_r9_base_held: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(base));
endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  order_e            order,
  input  logic [BEAT_W-1:0] first,
  input  logic [BEAT_W-1:0] beat_idx,
  output logic [BEAT_W-1:0] beat_addr
);
  logic [BEAT_W-1:0] xor_addr;
  logic [BEAT_W-1:0] add_addr;

  for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
    assign xor_addr[b] = first[b] ^ beat_idx[b];
  end

  assign add_addr = first + beat_idx;

  always_comb begin
    if (order == ORD_INTERLEAVED) beat_addr = xor_addr;
    else                          beat_addr = add_addr;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cen_n,
  input  logic              order_sel,
  input  logic              start,
  input  logic              advance,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out,
  output logic              last_beat,
  output logic              burst_active
);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat_idx;
  logic [BEAT_W-1:0] beat_addr;
  order_e            order;

  assign order = order_e'(order_sel);

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cen_n    (cen_n),
    .start    (start),
    .advance  (advance),
    .beat_idx (beat_idx),
    .active   (burst_active),
    .last     (last_beat)
  );

  burst_base_reg #(.ADDR_W(ADDR_W)) u_base (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (!cen_n && start),
    .addr_in (addr_in),
    .base    (base)
  );

  burst_order_map #(.BEAT_W(BEAT_W)) u_map (
    .order     (order),
    .first     (base[BEAT_W-1:0]),
    .beat_idx  (beat_idx),
    .beat_addr (beat_addr)
  );

  assign addr_out = {base[ADDR_W-1:BEAT_W], beat_addr};

  // R9
  a_r9_upper_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_active && !(!cen_n && start)) |=>
      (addr_out[ADDR_W-1:BEAT_W] == $past(addr_out[ADDR_W-1:BEAT_W])));
  // R8
  a_r8_last_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> burst_active);
  // R2
  a_r2_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (!cen_n && start) |=> (addr_out == $past(addr_in)));

  initial assert (UPPER_W >= 1) else $error("ADDR_W must exceed BEAT_W");
endmodule

// File: tb/sim_burst_addr_seq.sv
module sim_burst_addr_seq;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;

  typedef struct {
    logic [ADDR_W-1:0] addr;
    logic              last;
    logic              act;
    string             tag;
  } exp_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cen_n = 1'b0;
  logic              order_sel = 1'b1;
  logic              start = 1'b0;
  logic              advance = 1'b0;
  logic [ADDR_W-1:0] addr_in = '0;
  logic [ADDR_W-1:0] addr_out;
  logic              last_beat;
  logic              burst_active;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  exp_t exp_q[$];

  logic [ADDR_W-1:0] m_base = '0;
  logic [1:0]        m_idx = '0;
  logic              m_act = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_seq #(.ADDR_W(ADDR_W), .BEAT_W(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .order_sel(order_sel),
    .start(start), .advance(advance), .addr_in(addr_in),
    .addr_out(addr_out), .last_beat(last_beat), .burst_active(burst_active)
  );

  function automatic exp_t model_out(input logic ord, input string tag);
    exp_t e;
    logic [1:0] lo;
    lo = ord ? (m_base[1:0] ^ m_idx) : (m_base[1:0] + m_idx);
    e.addr = {m_base[ADDR_W-1:2], lo};
    e.last = m_act && (m_idx == 2'd3);
    e.act  = m_act;
    e.tag  = tag;
    return e;
  endfunction

  task automatic step(input logic c_n, input logic ord, input logic st,
                      input logic adv, input logic [ADDR_W-1:0] a,
                      input string tag);
    @(negedge clk);
    cen_n = c_n; order_sel = ord; start = st; advance = adv; addr_in = a;
    if (!c_n) begin
      if (st) begin
        m_base = a; m_idx = 2'd0; m_act = 1'b1;
      end else if (adv && m_act) begin
        m_idx = m_idx + 2'd1;
      end
    end
    exp_q.push_back(model_out(ord, tag));
  endtask

  task automatic burst(input logic ord, input logic [ADDR_W-1:0] a,
                       input string tag);
    step(1'b0, ord, 1'b1, 1'b0, a, tag);
    for (int k = 0; k < 3; k++) step(1'b0, ord, 1'b0, 1'b1, ~a, tag);
  endtask

  always begin
    @(posedge clk);
    #4;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_cmp++;
      if (addr_out !== e.addr || last_beat !== e.last || burst_active !== e.act) begin
        n_bad++;
        $display("FAIL %s: addr=%h last=%b act=%b expected addr=%h last=%b act=%b",
                 e.tag, addr_out, last_beat, burst_active, e.addr, e.last, e.act);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n_cmp++;
    if (addr_out !== '0 || last_beat !== 1'b0 || burst_active !== 1'b0) begin
      n_bad++;
      $display("FAIL R1: addr=%h last=%b act=%b expected addr=0000 last=0 act=0",
               addr_out, last_beat, burst_active);
    end
    // R5: advance with no burst loaded does nothing
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'h7777, "R5 idle advance");
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'h7777, "R5 idle advance");
    // R2 R3 R8: interleaved from every offset
    burst(1'b1, 16'h1230, "R3 interleaved 00");
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'hFFFF, "R8 wrap past last");
    burst(1'b1, 16'hABC1, "R3 interleaved 01");
    burst(1'b1, 16'h0012, "R3 interleaved 10");
    burst(1'b1, 16'h0FF3, "R3 interleaved 11");
    // R4: linear from every offset
    burst(1'b0, 16'h5550, "R4 linear 00");
    burst(1'b0, 16'h5551, "R4 linear 01");
    burst(1'b0, 16'h5552, "R4 linear 10");
    burst(1'b0, 16'h5553, "R4 linear 11");
    step(1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, "R8 linear wrap keeps upper R9");
    // R6: wait states ignore start and advance
    step(1'b0, 1'b1, 1'b1, 1'b0, 16'h4441, "R2 load before wait");
    step(1'b1, 1'b1, 1'b1, 1'b0, 16'h9999, "R6 start in wait");
    step(1'b1, 1'b1, 1'b0, 1'b1, 16'h9999, "R6 advance in wait");
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'h9999, "R9 upper held");
    // R7: restart mid-burst, start beats advance
    step(1'b0, 1'b1, 1'b1, 1'b1, 16'hBEE2, "R7 restart with advance");
    step(1'b0, 1'b1, 1'b0, 1'b1, 16'h0000, "R7 after restart");
    step(1'b0, 1'b0, 1'b1, 1'b0, 16'hC0D3, "R7 restart linear");
    step(1'b0, 1'b0, 1'b0, 1'b0, 16'h0000, "R9 no pulse holds");
    repeat (3) @(posedge clk);
    #5;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule